// File: doc/BRIEF.md
# PLL Feedback Multiplier Code Converter

This block translates a binary PLL feedback multiplier M into the scrambled 17-bit code that the PLL's feedback divider loads, and also turns such a code back into M. The code is not a binary field. It is the state of a 15-bit linear feedback shift register that has been stepped a number of times from a fixed seed, so each conversion walks the register one step per clock. A conversion can therefore take up to about 32k cycles. Multipliers 1 and 2, and the zero value, have fixed codes and finish at once.

Each conversion also produces the two loop-bandwidth select values for the final M: a proportional select and an integral select. They are packed with the code into one 32-bit configuration word that the PLL setup path writes as a unit. A controller selects the direction with `mode_i`, pulses `start_i`, waits for `done_o` and then reads the results. Results stay on the outputs until the next conversion completes. A code that cannot be decoded, or a multiplier out of range, raises `err_o` and zeros all results.

Top module: `pll_mcode_conv`

## Requirements
- R1: Encode (`mode_i`=0) of M=0, 1 and 2 gives codes 0, 0x18003 and 0x10003. `done_o` rises one cycle after the start and `busy_o` never rises.
- R2: Encode of M in 3..32768 starts from the LFSR state 0x4000 and makes 32769-M steps, one per clock. Each step shifts right by one and sets the new bit 14 to the XOR of the old bits 0 and 1. The result is the final state with code bits 16:15 at zero, and `mult_o` equals M.
- R3: Decode (`mode_i`=1) turns 0x18003 into 1 and 0x10003 into 2 immediately. Any other code loads bits 14:0 into the register and a counter set to 32769. Each clock the register shifts left by one inside 15 bits, bit 0 takes the XOR of the old bits 14 and 0, and the counter is decremented. When the state reaches 0x4000, the counter value is M.
- R4: A decode raises `err_o` and drives `mult_o`, `code_o` and `word_o` to zero in these cases: the code has bit 15 or 16 set and is not a special code; the code is 0x4000 (M would be 32769); or the state has not reached 0x4000 when the counter hits zero. A code of zero takes exactly 32769 busy cycles before it is flagged.
- R5: An encode of M above 32768 raises `err_o` one cycle after the start, zeros all results, and `busy_o` never rises.
- R6: `word_o[21:17]` holds the proportional select. It is M/2+1 (integer division) for M<60 and 31 otherwise.
- R7: `word_o[27:22]` holds the integral select: 1 for M>16384, 2 for M>8192, 4 for M>2048, 8 for M>=501, 4*ceil(1024/(M+9)) for 60<=M<=500, and (M AND 0x3C)+4 below 60. `word_o[31:28]` is zero.
- R8: `word_o[16:0]` equals `code_o` after every successful conversion.
- R9: A start request that arrives while `busy_o` is high is ignored. The running conversion completes with its own result, and no extra `done_o` follows.
- R10: `done_o` is high for one cycle per conversion. `code_o`, `mult_o`, `word_o` and `err_o` change only in the cycle `done_o` is high, and they reset to zero.
- R11: `busy_o` is high in every cycle from the clock after an accepted stepped conversion until `done_o` rises. The number of high cycles equals the number of steps, and `busy_o` is low whenever `done_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start a conversion (ignored while busy) |
| mode_i | input | 1 | 0 = encode M to code, 1 = decode code to M |
| mult_i | input | 16 | Multiplier M for encode |
| code_i | input | 17 | Code for decode |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle result-valid pulse |
| err_o | output | 1 | Last conversion was invalid |
| mult_o | output | 16 | Resulting or echoed multiplier |
| code_o | output | 17 | Resulting or echoed code |
| word_o | output | 32 | Packed code and bandwidth selects |

## Verification
Several properties are checked on every cycle. The outputs stay stable between `done_o` pulses, an error zeros all results, and the word's code field matches `code_o`. The bandwidth fields are saturated for large M, and `busy_o` falls only as `done_o` rises. Only the bench's scenarios can show the exact LFSR codes and their step counts. They also show that encode followed by decode returns M, that a zero code takes the full count before its error, and that a start pulse in the middle of a long encode is dropped.

// File: rtl/pll_mcode_pkg.sv
package pll_mcode_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ENC, ST_DEC} conv_st_e;
  typedef enum logic {OP_ENC = 1'b0, OP_DEC = 1'b1} conv_op_e;
endpackage

// File: rtl/pll_mcode_lfsr.sv
module pll_mcode_lfsr #(
  parameter int W = 15
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         step,
  input  logic         fwd,
  output logic [W-1:0] state_q,
  output logic [W-1:0] state_nxt
);
  logic [W-1:0] st_d;

  // forward: left shift, feedback XOR(top, bottom) into bit 0
  // reverse: right shift, feedback XOR(bit0, bit1) into the top bit
  always_comb begin
    if (fwd) state_nxt = {state_q[W-2:0], state_q[W-1] ^ state_q[0]};
    else     state_nxt = {state_q[0] ^ state_q[1], state_q[W-1:1]};
    st_d = load ? load_val : state_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            state_q <= '0;
    else if (load || step) state_q <= st_d;
  end
endmodule

// File: rtl/pll_mcode_bw.sv
module pll_mcode_bw #(
  parameter int M_W    = 16,
  parameter int SELP_W = 5,
  parameter int SELI_W = 6
) (
  input  logic [M_W-1:0]    mult,
  output logic [SELP_W-1:0] selp,
  output logic [SELI_W-1:0] seli
);
  localparam int PW = M_W + 4;
  localparam logic [M_W-1:0] LIM_SMALL = M_W'(60);
  localparam logic [M_W-1:0] LIM_MID   = M_W'(501);
  localparam logic [M_W-1:0] LIM_2K    = M_W'(2048);
  localparam logic [M_W-1:0] LIM_8K    = M_W'(8192);
  localparam logic [M_W-1:0] LIM_16K   = M_W'(16384);
  localparam logic [PW-1:0]  NUMER     = PW'(1024);

  logic [M_W-1:0] dsum;
  logic [3:0]     qsel;
  logic [PW-1:0]  prod;

  always_comb begin
    dsum = mult + M_W'(9);
    qsel = 4'd15;
    prod = '0;
    // smallest q with q*(M+9) >= 1024 : ceiling of the quotient
    for (int q = 15; q >= 1; q--) begin
      prod = PW'(q) * {4'b0000, dsum};
      if (prod >= NUMER) qsel = 4'(q);
    end
  end

  always_comb begin
    if (mult < LIM_SMALL) selp = SELP_W'(mult[5:1]) + SELP_W'(1);
    else                  selp = SELP_W'(31);

    if (mult > LIM_16K)        seli = SELI_W'(1);
    else if (mult > LIM_8K)    seli = SELI_W'(2);
    else if (mult > LIM_2K)    seli = SELI_W'(4);
    else if (mult >= LIM_MID)  seli = SELI_W'(8);
    else if (mult >= LIM_SMALL) seli = SELI_W'({qsel, 2'b00});
    else                       seli = SELI_W'({mult[5:2], 2'b00}) + SELI_W'(4);
  end
endmodule

// File: rtl/pll_mcode_conv.sv
module pll_mcode_conv
  import pll_mcode_pkg::*;
#(
  parameter int M_W    = 16,
  parameter int CODE_W = 17,
  parameter int LFSR_W = 15,
  parameter int MAX_M  = 32768,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              mode_i,
  input  logic [M_W-1:0]    mult_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [M_W-1:0]    mult_o,
  output logic [CODE_W-1:0] code_o,
  output logic [WORD_W-1:0] word_o
);
  localparam int SELP_W = 5;
  localparam int SELI_W = 6;
  localparam int PAD_W  = WORD_W - CODE_W - SELP_W - SELI_W;
  localparam int HI_W   = CODE_W - LFSR_W;
  localparam logic [LFSR_W-1:0] SEED     = {1'b1, {(LFSR_W-1){1'b0}}};
  localparam logic [CODE_W-1:0] CODE_M1  = CODE_W'(17'h18003);
  localparam logic [CODE_W-1:0] CODE_M2  = CODE_W'(17'h10003);
  localparam logic [M_W-1:0]    MAX_V    = M_W'(MAX_M);
  localparam logic [M_W-1:0]    CNT_INIT = M_W'(MAX_M + 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_core_n = rsync_q[1];

  conv_st_e          st_q, st_d;
  logic [M_W-1:0]    cnt_q, cnt_d, opm_q, opm_d, cnt_dec;
  logic [CODE_W-1:0] opc_q, opc_d;
  logic              lf_load, lf_step, lf_fwd;
  logic [LFSR_W-1:0] lf_val, lf_q, lf_nxt;
  logic              fin, fin_err;
  logic [M_W-1:0]    fin_mult;
  logic [CODE_W-1:0] fin_code;
  logic [SELP_W-1:0] selp;
  logic [SELI_W-1:0] seli;

  pll_mcode_lfsr #(.W(LFSR_W)) u_lfsr (
    .clk(clk), .rst_n(rst_core_n), .load(lf_load), .load_val(lf_val),
    .step(lf_step), .fwd(lf_fwd), .state_q(lf_q), .state_nxt(lf_nxt)
  );

  pll_mcode_bw #(.M_W(M_W), .SELP_W(SELP_W), .SELI_W(SELI_W)) u_bw (
    .mult(fin_mult), .selp(selp), .seli(seli)
  );

  assign lf_fwd  = (st_q == ST_DEC);
  assign cnt_dec = cnt_q - M_W'(1);

  // next-state logic
  always_comb begin
    st_d = st_q; cnt_d = cnt_q; opm_d = opm_q; opc_d = opc_q;
    lf_load = 1'b0; lf_val = SEED; lf_step = 1'b0;
    fin = 1'b0; fin_err = 1'b0; fin_mult = '0; fin_code = '0;
    unique case (st_q)
      ST_IDLE: if (start_i) begin
        if (conv_op_e'(mode_i) == OP_DEC) begin
          opc_d = code_i;
          if (code_i == CODE_M1) begin
            fin = 1'b1; fin_mult = M_W'(1); fin_code = code_i;
          end else if (code_i == CODE_M2) begin
            fin = 1'b1; fin_mult = M_W'(2); fin_code = code_i;
          end else if (code_i[CODE_W-1:LFSR_W] != '0 || code_i[LFSR_W-1:0] == SEED) begin
            fin = 1'b1; fin_err = 1'b1;
          end else begin
            lf_load = 1'b1; lf_val = code_i[LFSR_W-1:0];
            cnt_d = CNT_INIT; st_d = ST_DEC;
          end
        end else begin
          opm_d = mult_i;
          if (mult_i == '0) begin
            fin = 1'b1;
          end else if (mult_i == M_W'(1)) begin
            fin = 1'b1; fin_mult = mult_i; fin_code = CODE_M1;
          end else if (mult_i == M_W'(2)) begin
            fin = 1'b1; fin_mult = mult_i; fin_code = CODE_M2;
          end else if (mult_i > MAX_V) begin
            fin = 1'b1; fin_err = 1'b1;
          end else begin
            lf_load = 1'b1; lf_val = SEED;
            cnt_d = CNT_INIT - mult_i; st_d = ST_ENC;
          end
        end
      end
      ST_ENC: begin
        lf_step = 1'b1; cnt_d = cnt_dec;
        if (cnt_q == M_W'(1)) begin
          fin = 1'b1; fin_mult = opm_q; fin_code = {{HI_W{1'b0}}, lf_nxt};
          st_d = ST_IDLE;
        end
      end
      ST_DEC: begin
        lf_step = 1'b1; cnt_d = cnt_dec;
        if (lf_nxt == SEED && cnt_dec != '0) begin
          fin = 1'b1; fin_mult = cnt_dec; fin_code = opc_q; st_d = ST_IDLE;
        end else if (cnt_dec == '0) begin
          fin = 1'b1; fin_err = 1'b1; st_d = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      st_q <= ST_IDLE; cnt_q <= '0; opm_q <= '0; opc_q <= '0;
    end else begin
      st_q <= st_d; cnt_q <= cnt_d; opm_q <= opm_d; opc_q <= opc_d;
    end
  end

  // result registers, enabled on completion only
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      done_o <= 1'b0; err_o <= 1'b0; mult_o <= '0; code_o <= '0; word_o <= '0;
    end else begin
      done_o <= fin;
      if (fin) begin
        err_o <= fin_err;
        if (fin_err) begin
          mult_o <= '0; code_o <= '0; word_o <= '0;
        end else begin
          mult_o <= fin_mult; code_o <= fin_code;
          word_o <= {{PAD_W{1'b0}}, seli, selp, fin_code};
        end
      end
    end
  end

  assign busy_o = (st_q != ST_IDLE);
endmodule

// File: rtl/pll_mcode_conv_chk.sv
module pll_mcode_conv_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start_i,
  input logic        busy_o,
  input logic        done_o,
  input logic        err_o,
  input logic [15:0] mult_o,
  input logic [16:0] code_o,
  input logic [31:0] word_o
);
  p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
  p_busy_end_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(code_o) && $stable(mult_o) && $stable(word_o) && $stable(err_o)));
  p_err_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (code_o == '0 && mult_o == '0 && word_o == '0));
  p_word_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !err_o |-> (word_o[16:0] == code_o));
  p_selp_sat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!err_o && mult_o >= 16'd60) |-> (word_o[21:17] == 5'd31));
  p_seli_top_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!err_o && mult_o > 16'd16384) |-> (word_o[27:22] == 6'd1 && word_o[31:28] == 4'd0));
  p_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> (busy_o || done_o));
endmodule

bind pll_mcode_conv pll_mcode_conv_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o), .done_o(done_o),
  .err_o(err_o), .mult_o(mult_o), .code_o(code_o), .word_o(word_o)
);

// File: tb/pll_mcode_conv_test.sv
module pll_mcode_conv_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0, mode_i = 1'b0;
  logic [15:0] mult_i = '0;
  logic [16:0] code_i = '0;
  logic        busy_o, done_o, err_o;
  logic [15:0] mult_o;
  logic [16:0] code_o;
  logic [31:0] word_o;

  pll_mcode_conv uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic        err;
    logic [15:0] mult;
    logic [16:0] code;
    logic [31:0] word;
    string       req;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0, failures = 0;
  bit   finished = 0;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // reference model taken from the requirements
  function automatic logic [16:0] ref_enc(int m);
    logic [14:0] x;
    if (m == 0) return 17'h0;
    if (m == 1) return 17'h18003;
    if (m == 2) return 17'h10003;
    x = 15'h4000;
    for (int i = m; i <= 32768; i++) x = {x[0] ^ x[1], x[14:1]};
    return {2'b00, x};
  endfunction

  function automatic int ref_dec(logic [16:0] c);
    logic [14:0] x;
    int i;
    if (c == 17'h18003) return 1;
    if (c == 17'h10003) return 2;
    if (c[16:15] != 2'b00) return -1;
    x = c[14:0]; i = 32769;
    while (x != 15'h4000 && i > 0) begin
      x = {x[13:0], x[14] ^ x[0]}; i--;
    end
    if (i == 0 || i > 32768) return -1;
    return i;
  endfunction

  function automatic int ref_selp(int m);
    return (m < 60) ? (m / 2 + 1) : 31;
  endfunction

  function automatic int ref_seli(int m);
    if (m > 16384) return 1;
    if (m > 8192)  return 2;
    if (m > 2048)  return 4;
    if (m >= 501)  return 8;
    if (m >= 60)   return 4 * ((1024 + m + 8) / (m + 9));
    return (m & 32'h3c) + 4;
  endfunction

  function automatic exp_t mk_ok(int m, logic [16:0] c, string req);
    exp_t e;
    e.err = 1'b0; e.mult = 16'(m); e.code = c; e.req = req;
    e.word = (32'(ref_seli(m)) << 22) | (32'(ref_selp(m)) << 17) | {15'b0, c};
    return e;
  endfunction

  function automatic exp_t mk_err(string req);
    exp_t e;
    e.err = 1'b1; e.mult = '0; e.code = '0; e.word = '0; e.req = req;
    return e;
  endfunction

  // monitor: pop and compare on each completion
  always @(negedge clk) begin
    if (rst_n && done_o) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R9", "unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(err_o == e.err,   e.req, "err",  err_o,  e.err);
        chk(code_o == e.code, e.req, "code", code_o, e.code);
        chk(mult_o == e.mult, e.req, "mult", mult_o, e.mult);
        chk(word_o == e.word, e.req, "word", word_o, e.word);
      end
    end
  end

  // driver: push expectation, pulse start, count busy cycles until done
  task automatic run_op(bit mode, logic [15:0] m, logic [16:0] c, exp_t e,
                        int exp_busy, string breq, int poke_at);
    int nb = 0;
    exp_q.push_back(e);
    mode_i = mode; mult_i = m; code_i = c; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    while (!done_o) begin
      if (busy_o) nb++;
      if (nb == poke_at && poke_at > 0) begin
        start_i = 1'b1; mode_i = 1'b0; mult_i = 16'd5;
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk);
    end
    start_i = 1'b0;
    chk(nb == exp_busy, breq, "busy cycles", nb, exp_busy);
  endtask

  task automatic enc(int m, string req, int poke_at = -1);
    if (m > 32768) run_op(1'b0, 16'(m), '0, mk_err(req), 0, req, -1);
    else run_op(1'b0, 16'(m), '0, mk_ok(m, ref_enc(m), req),
                (m < 3) ? 0 : 32769 - m, "R11", poke_at);
  endtask

  task automatic dec(logic [16:0] c, string req);
    int m = ref_dec(c);
    if (m < 0) begin
      int nb = (c == 17'h0) ? 32769 : 0;
      run_op(1'b1, '0, c, mk_err(req), nb, req, -1);
    end else begin
      int nb = (c == 17'h18003 || c == 17'h10003) ? 0 : 32769 - m;
      run_op(1'b1, '0, c, mk_ok(m, c, req), nb, "R11", -1);
    end
  endtask

  task automatic roundtrip(int m);
    enc(m, "R2");
    dec(ref_enc(m), "R3");
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      failures++; checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R10: reset state
    chk(!busy_o && !done_o && !err_o, "R10", "reset flags", {busy_o, done_o, err_o}, 0);
    chk(code_o == 0 && mult_o == 0 && word_o == 0, "R10", "reset data", word_o, 0);

    enc(0, "R1"); enc(1, "R1"); enc(2, "R1");
    enc(32769, "R5"); enc(65535, "R5");
    dec(17'h18003, "R3"); dec(17'h10003, "R3");
    dec(17'h04000, "R4"); dec(17'h08005, "R4"); dec(17'h1a003, "R4");

    roundtrip(32768); roundtrip(32767); roundtrip(30000); roundtrip(25000);

    // R10: results hold and done stays a single pulse
    repeat (4) begin
      @(negedge clk);
      chk(!done_o && code_o == ref_enc(25000) && mult_o == 16'd25000, "R10",
          "hold after done", code_o, ref_enc(25000));
    end

    enc(20000, "R9", 100);   // R9: start pulse mid-run must be dropped; R7 SELI=1
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0 && !busy_o, "R9", "pending after ignored start", exp_q.size(), 0);
    enc(16384, "R7");        // R7 SELI=2
    enc(100, "R6");          // R6 SELP=31, R7 ceiling form
    enc(59, "R6");           // R6 small-M form, R7 masked form
    dec(17'h0, "R4");        // R4 full count then error

    repeat (2) @(negedge clk);
    chk(exp_q.size() == 0, "R10", "results left unseen", exp_q.size(), 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule